// File: doc/BRIEF.md
# Sequential Multiply Step Unit

This block forms the 64-bit unsigned product of two 32-bit operands by running a chain of single-bit multiply steps, one per clock. Each step works on a partial-product register, a multiplier register that also collects the low half of the product, and a set of four condition flags. The step shifts the partial product right and puts the sign of the previous add (N XOR V) into its top bit. It moves the partial product's old low bit into the top of the multiplier register. It then adds the multiplicand when the multiplier register's old low bit was set, and updates the flags from that add.

A pulse on `start_i` while the unit is idle loads the operands. The controller then runs one step for each multiplier bit. A last step with a zero addend lines the product up: the high word sits in the partial-product register and the low word in the multiplier register. A single correction cycle follows and turns the signed-multiplicand result of the step chain into an unsigned product. `busy_o` covers the whole run, and `done_o` pulses once when the product is ready.

Top module: `mul_step_unit`

## Requirements
- R1: After reset, busy_o, done_o, prod_hi_o, prod_lo_o and flags_o are all zero.
- R2: A start_i sampled while idle raises busy_o on the next cycle. busy_o stays high for exactly WIDTH+2 cycles (34 by default). done_o is high for exactly one cycle, the cycle right after busy_o falls.
- R3: In every step except the last, the addend is the loaded multiplicand if bit 0 of the multiplier register was 1 before the step, and zero otherwise. A zero multiplier therefore gives a zero product.
- R4: Each step shifts the multiplier register right by one bit and fills its top bit with the partial product's bit 0 from before the step.
- R5: Each step shifts the partial product right by one bit and fills its top bit with N XOR V from the previous step. The add result becomes the new partial product.
- R6: Each step sets the flags as a normal add of shifted partial product and addend: N is result bit 31, Z means the result is zero, V is signed overflow, C is the carry out. flags_o packs them as {N,Z,V,C} in bits 3..0.
- R7: Starting from a cleared partial product and cleared flags, the chain runs WIDTH steps plus one final step with a zero addend. After that the partial product holds the high word and the multiplier register holds the low word of signed(multiplicand) times unsigned(multiplier).
- R8: When done_o is high, {prod_hi_o, prod_lo_o} equals the unsigned 64-bit product of the two operands that were loaded. The correction cycle adds the multiplier to the high word when bit 31 of the multiplicand is set.
- R9: A start_i sampled while busy_o is high is ignored. The run in progress completes with its original operands.
- R10: When done_o is high, flags_o holds the flags of the final zero-addend step: N is bit 63 and Z is (bits 63..32 == 0) of the uncorrected signed-by-unsigned product, and V and C are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request; accepted only when idle |
| mcand_i | input | 32 | Multiplicand, sampled with an accepted start |
| mplier_i | input | 32 | Multiplier, sampled with an accepted start |
| busy_o | output | 1 | High while steps or the correction run |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| prod_hi_o | output | 32 | High product word |
| prod_lo_o | output | 32 | Low product word |
| flags_o | output | 4 | Step flags {N,Z,V,C} |

## Verification
A start request and the completion pulse can fall in the same cycle: done_o is high while the controller is already idle, so a start presented then has to be accepted at once. The bench triggers this by issuing the next start in the very cycle it sees done_o. It checks that the new run gets a full-length busy window and the product of the new operands. The bench also holds start_i high with different operands for much of a run. That result must still match the first operands, and busy_o must keep its normal length.

// File: rtl/mstep_pkg.sv
// Package: shared state and flag types for the multiply step unit.
// Assumes flag packing {N,Z,V,C} from bit 3 down to bit 0.
package mstep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_FIX  = 2'd2
    } mstep_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } mstep_flags_t;

    localparam mstep_flags_t FLAGS_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/mstep_alu.sv
// Module: mstep_alu
// Combinational single multiply step. It picks the addend from the
// multiplier register's low bit, shifts the partial product right with the
// previous N^V filling the top bit, shifts the multiplier register right
// with the partial product's low bit filling the top bit, and adds.
// Assumes the operands are exactly WIDTH bits wide (no upper bits exist).
module mstep_alu
    import mstep_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] part_i,
    input  logic [WIDTH-1:0] yreg_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  mstep_flags_t     flags_i,
    input  logic             zero_add_i,
    output logic [WIDTH-1:0] part_o,
    output logic [WIDTH-1:0] yreg_o,
    output mstep_flags_t     flags_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] addend;
    logic [WIDTH-1:0] shifted;
    logic [WIDTH:0]   sum_ext;
    logic [WIDTH-1:0] sum;

    // Choose the addend: the multiplicand when the old low multiplier bit is set.
    always_comb begin
        if (zero_add_i || !yreg_i[0]) begin
            addend = '0;
        end else begin
            addend = mcand_i;
        end
    end

    // Shift the partial product with the previous sign (N xor V) entering on top.
    always_comb begin
        shifted = {flags_i.n ^ flags_i.v, part_i[MSB:1]};
    end

    // Full add with carry out.
    always_comb begin
        sum_ext = {1'b0, shifted} + {1'b0, addend};
        sum     = sum_ext[MSB:0];
    end

    // New multiplier register: the old partial-product low bit enters on top.
    always_comb begin
        yreg_o = {part_i[0], yreg_i[MSB:1]};
    end

    // Result and flags of a normal flag-setting add.
    always_comb begin
        part_o    = sum;
        flags_o.n = sum[MSB];
        flags_o.z = (sum == '0);
        flags_o.v = (shifted[MSB] == addend[MSB]) && (sum[MSB] != shifted[MSB]);
        flags_o.c = sum_ext[WIDTH];
    end

endmodule

// File: rtl/mstep_regs.sv
// Module: mstep_regs
// State registers of the multiply step unit: partial product, multiplier
// register, captured multiplicand and multiplier, and the flags. A load
// clears the partial product and flags, a step takes the ALU results, and
// the correction cycle adds the saved multiplier to the high word when the
// multiplicand's top bit is set. Assumes load, step and fix never overlap.
module mstep_regs
    import mstep_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             zero_add_i,
    input  logic             fix_i,
    input  logic [WIDTH-1:0] mcand_in_i,
    input  logic [WIDTH-1:0] mplier_in_i,
    input  logic [WIDTH-1:0] part_nx_i,
    input  logic [WIDTH-1:0] yreg_nx_i,
    input  mstep_flags_t     flags_nx_i,
    output logic [WIDTH-1:0] part_o,
    output logic [WIDTH-1:0] yreg_o,
    output logic [WIDTH-1:0] mcand_o,
    output mstep_flags_t     flags_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] part_q;
    logic [WIDTH-1:0] yreg_q;
    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH-1:0] mplier_q;
    mstep_flags_t     flags_q;
    logic [WIDTH-1:0] fix_add;

    // Correction term for an unsigned multiplicand.
    always_comb begin
        fix_add = mcand_q[MSB] ? mplier_q : '0;
    end

    // Operand capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load_i) begin
            mcand_q  <= mcand_in_i;
            mplier_q <= mplier_in_i;
        end
    end

    // Partial product: clear, step or correct.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
        end else if (load_i) begin
            part_q <= '0;
        end else if (step_i) begin
            part_q <= part_nx_i;
        end else if (fix_i) begin
            part_q <= part_q + fix_add;
        end
    end

    // Multiplier register: load the multiplier, then shift per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            yreg_q <= '0;
        end else if (load_i) begin
            yreg_q <= mplier_in_i;
        end else if (step_i) begin
            yreg_q <= yreg_nx_i;
        end
    end

    // Flags: cleared on load, updated on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= FLAGS_CLEAR;
        end else if (load_i) begin
            flags_q <= FLAGS_CLEAR;
        end else if (step_i) begin
            flags_q <= flags_nx_i;
        end
    end

    assign part_o  = part_q;
    assign yreg_o  = yreg_q;
    assign mcand_o = mcand_q;
    assign flags_o = flags_q;

    // R4
    y_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (yreg_q[MSB] == $past(part_q[0])));

    // R7
    load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (part_q == '0) && (flags_q == FLAGS_CLEAR));

    // R10
    last_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && zero_add_i) |=> (!flags_q.v && !flags_q.c));

    // R8
    fix_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_i && !mcand_q[MSB]) |=> $stable(part_q));

    // R8
    fix_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_i |=> ($stable(yreg_q) && $stable(flags_q)));

endmodule

// File: rtl/mstep_ctrl.sv
// Module: mstep_ctrl
// Sequencer: accepts a start only when idle, runs STEPS step cycles with the
// last one using a zero addend, then one correction cycle, then pulses done.
// Assumes STEPS >= 2.
module mstep_ctrl
    import mstep_pkg::*;
#(
    parameter int STEPS = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic zero_add_o,
    output logic fix_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(STEPS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    mstep_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             last_step;

    // Decode the sequencer outputs from the state.
    always_comb begin
        last_step  = (cnt_q == LAST);
        load_o     = (state_q == ST_IDLE) && start_i;
        step_o     = (state_q == ST_STEP);
        zero_add_o = step_o && last_step;
        fix_o      = (state_q == ST_FIX);
        busy_o     = (state_q != ST_IDLE);
    end

    // State transitions and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_STEP;
                        cnt_q   <= '0;
                    end
                end
                ST_STEP: begin
                    if (last_step) begin
                        state_q <= ST_FIX;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_FIX: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Completion pulse, one cycle after the correction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FIX);
        end
    end

    assign done_o = done_q;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_o);

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R7
    fix_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_add_o |=> fix_o);

endmodule

// File: rtl/mul_step_unit.sv
// Module: mul_step_unit (top)
// Sequential unsigned WIDTH x WIDTH multiplier built from single-bit multiply
// steps. The high word comes from the partial-product register and the low
// word from the multiplier register. Assumes start is ignored while busy.
module mul_step_unit
    import mstep_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] prod_hi_o,
    output logic [WIDTH-1:0] prod_lo_o,
    output logic [3:0]       flags_o
);

    localparam int STEPS = WIDTH + 1;

    logic             load;
    logic             step;
    logic             zero_add;
    logic             fix;
    logic [WIDTH-1:0] part_q;
    logic [WIDTH-1:0] yreg_q;
    logic [WIDTH-1:0] mcand_q;
    mstep_flags_t     flags_q;
    logic [WIDTH-1:0] part_nx;
    logic [WIDTH-1:0] yreg_nx;
    mstep_flags_t     flags_nx;

    mstep_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .load_o     (load),
        .step_o     (step),
        .zero_add_o (zero_add),
        .fix_o      (fix),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    mstep_alu #(.WIDTH(WIDTH)) u_alu (
        .part_i     (part_q),
        .yreg_i     (yreg_q),
        .mcand_i    (mcand_q),
        .flags_i    (flags_q),
        .zero_add_i (zero_add),
        .part_o     (part_nx),
        .yreg_o     (yreg_nx),
        .flags_o    (flags_nx)
    );

    mstep_regs #(.WIDTH(WIDTH)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .step_i      (step),
        .zero_add_i  (zero_add),
        .fix_i       (fix),
        .mcand_in_i  (mcand_i),
        .mplier_in_i (mplier_i),
        .part_nx_i   (part_nx),
        .yreg_nx_i   (yreg_nx),
        .flags_nx_i  (flags_nx),
        .part_o      (part_q),
        .yreg_o      (yreg_q),
        .mcand_o     (mcand_q),
        .flags_o     (flags_q)
    );

    // Product and flag outputs straight from the state registers.
    always_comb begin
        prod_hi_o = part_q;
        prod_lo_o = yreg_q;
        flags_o   = flags_q;
    end

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(mcand_q));

endmodule

// File: tb/sim_mul_step_unit.sv
// Scoreboard bench: the driver pushes expected products, the monitor pops
// and compares them on each done pulse and checks the busy window length.
module sim_mul_step_unit;

    typedef struct {
        logic [31:0] hi;
        logic [31:0] lo;
        logic [3:0]  fl;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] mcand = '0;
    logic [31:0] mplier = '0;
    logic        busy;
    logic        done;
    logic [31:0] prod_hi;
    logic [31:0] prod_lo;
    logic [3:0]  flags;

    int errors = 0;
    int checks = 0;
    int busy_cnt = 0;
    int cycles = 0;
    int completed = 0;
    exp_t expq[$];

    mul_step_unit #(.WIDTH(32)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .mcand_i   (mcand),
        .mplier_i  (mplier),
        .busy_o    (busy),
        .done_o    (done),
        .prod_hi_o (prod_hi),
        .prod_lo_o (prod_lo),
        .flags_o   (flags)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input string tag);
        exp_t e;
        logic [63:0] full;
        logic [63:0] pre;
        full = {32'b0, a} * {32'b0, b};
        pre  = full - (a[31] ? {b, 32'b0} : 64'b0);
        e.hi  = full[63:32];
        e.lo  = full[31:0];
        e.fl  = {pre[63], (pre[63:32] == 32'b0), 1'b0, 1'b0};
        e.tag = tag;
        return e;
    endfunction

    // Driver: queue the expectation and present a one-cycle start.
    task automatic launch(input logic [31:0] a, input logic [31:0] b, input string tag);
        expq.push_back(model(a, b, tag));
        start  = 1'b1;
        mcand  = a;
        mplier = b;
        @(negedge clk);
        start  = 1'b0;
        mcand  = ~a;
        mplier = ~b;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // Monitor: busy window length and scoreboard compare at each done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cnt++;
            if (done) begin
                check(busy_cnt == 34, "R2 busy length", 64'(busy_cnt), 64'd34);
                busy_cnt = 0;
                if (expq.size() == 0) begin
                    check(1'b0, "R2 unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check({prod_hi, prod_lo} == {e.hi, e.lo},
                          {"R3 R4 R5 R7 R8 product ", e.tag},
                          {prod_hi, prod_lo}, {e.hi, e.lo});
                    check(flags == e.fl, {"R6 R10 flags ", e.tag},
                          64'(flags), 64'(e.fl));
                end
                completed++;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1 busy/done", {62'b0, busy, done}, 64'd0);
        check({prod_hi, prod_lo} == 64'b0, "R1 product", {prod_hi, prod_lo}, 64'd0);
        check(flags == 4'b0, "R1 flags", 64'(flags), 64'd0);

        // Corner operands
        launch(32'h0, 32'h0, "0x0");                   wait_done();
        @(negedge clk);
        launch(32'h0, 32'hFFFF_FFFF, "0xmax");         wait_done();
        @(negedge clk);
        launch(32'hFFFF_FFFF, 32'h0, "R3 zero multiplier"); wait_done();
        @(negedge clk);
        launch(32'h1, 32'h1, "1x1");                   wait_done();
        @(negedge clk);
        launch(32'h1, 32'hFFFF_FFFF, "1xmax");         wait_done();
        @(negedge clk);
        launch(32'hFFFF_FFFF, 32'h1, "maxx1");         wait_done();
        @(negedge clk);
        launch(32'hFFFF_FFFF, 32'hFFFF_FFFF, "maxxmax"); wait_done();
        @(negedge clk);
        launch(32'h8000_0000, 32'h8000_0000, "R5 msbxmsb"); wait_done();
        @(negedge clk);
        launch(32'h8000_0000, 32'hFFFF_FFFF, "R5 msbxmax"); wait_done();
        @(negedge clk);
        launch(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R6 overflow path"); wait_done();

        // Back-to-back: new start in the same cycle done is high (R2)
        launch(32'h1234_5678, 32'h9ABC_DEF0, "R2 back-to-back"); wait_done();
        launch(32'hDEAD_BEEF, 32'h0BAD_F00D, "R2 back-to-back 2"); wait_done();
        @(negedge clk);

        // R9: start held with other operands while busy
        expq.push_back(model(32'hCAFE_0001, 32'h8765_4321, "R9 start while busy"));
        start  = 1'b1;
        mcand  = 32'hCAFE_0001;
        mplier = 32'h8765_4321;
        @(negedge clk);
        mcand  = 32'h1111_1111;
        mplier = 32'h2222_2222;
        repeat (20) @(negedge clk);
        start = 1'b0;
        wait_done();
        @(negedge clk);

        // Random operands
        for (int i = 0; i < 20; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = $urandom();
            b = $urandom();
            launch(a, b, "random");
            wait_done();
            @(negedge clk);
        end

        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R2 all runs completed", 64'(expq.size()), 64'd0);
        check(completed == 33, "R2 done count", 64'(completed), 64'd33);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule